// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Front End

This block sits between a host processor bus and the two serial channels of a serial controller. It decodes a 4-bit address into sixteen locations. A read and a write to the same offset usually reach different registers. The block holds the configuration bytes that the channels and the shared logic use: two mode bytes and a clock-select byte per channel, plus auxiliary control, interrupt mask, interrupt vector, output-pin configuration, the output-pin levels and the 16-bit counter preload.

Status, received data, interrupt sources, input-pin levels and the live counter value come in from neighbouring logic. They are returned on reads. The neighbouring logic gets single-cycle strobes:
- pop for a receive-holding read,
- push for a transmit-holding write,
- a command strobe per channel,
- counter start and counter stop.

The byte that was written goes out beside the write strobes.

Each channel's two mode bytes share one offset. A per-channel pointer sends the first access to the first mode byte and every later access to the second. Only reset or a pointer-reset command sends the pointer back. Four accesses at the top of the map store nothing; the access alone fires an action.

Top module: `dsh_host_regs`

## Requirements
- R1: After synchronous active-low reset, every stored byte, the output-pin byte `pin_out`, the read byte `rdata` and every strobe are 0. Both mode pointers select the first mode byte.
- R2: The byte written at offset 0x1, 0x9, 0x4, 0x5, 0xC, 0xD, 0x6 or 0x7 appears one clock later on the matching output, in that order: `clk_sel_a`, `clk_sel_b`, `aux_ctl`, `irq_mask`, `irq_vec`, `pin_cfg`, `cnt_load[15:8]` and `cnt_load[7:0]`.
- R3: `rdata` is loaded one clock after the start of a read and holds until the next read. It returns the following:
  - 0x1: `stat_a`; 0x9: `stat_b`
  - 0x3: `rxd_a`; 0xB: `rxd_b`
  - 0x4: `pin_chg`; 0x5: `irq_src`
  - 0x6: `cnt_now[15:8]`; 0x7: `cnt_now[7:0]`
  - 0xC: `irq_vec`; 0xD: `pin_lvl`
- R4: A read of offset 0x2 returns `irq_src & irq_mask`.
- R5: A read of offset 0xA returns 0x00, fires no strobe and changes no stored byte.
- R6: Offset 0x0 belongs to channel A and offset 0x8 to channel B. Starting from the first mode byte, the first read or write at a channel's offset reaches that channel's first mode byte, and later accesses reach its second. A write to one mode byte leaves the other unchanged.
- R7: A write to a channel's command offset (0x2 for A, 0xA for B) with data bits [6:4] = 3'b001 returns only that channel's pointer to the first mode byte, and fires no command strobe. Without such a write, the pointer stays on the second mode byte.
- R8: Any other write to a channel's command offset pulses `cmd_stb[ch]` for one cycle, with the written byte on `stb_data`. Channel A is bit 0 and channel B is bit 1.
- R9: A read of offset 0x3 or 0xB pulses `rx_pop[ch]` for one cycle. A write of offset 0x3 or 0xB pulses `tx_push[ch]` for one cycle, with the written byte on `stb_data`.
- R10: A read of 0xE pulses `cnt_start` and a read of 0xF pulses `cnt_stop`, each for one cycle. Both return 0x00 and store nothing.
- R11: A write of 0xE sets every `pin_out` bit whose data bit is 1. A write of 0xF clears every `pin_out` bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R12: An access that holds `sel` with `rd_en` or `wr_en` for several cycles fires each strobe once and moves a pointer once. Both act on the first active cycle only. If both `rd_en` and `wr_en` are high, the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| stat_a | input | 8 | Channel A status |
| stat_b | input | 8 | Channel B status |
| rxd_a | input | 8 | Channel A received byte |
| rxd_b | input | 8 | Channel B received byte |
| irq_src | input | 8 | Raw interrupt sources |
| pin_chg | input | 8 | Input-pin change flags |
| pin_lvl | input | 8 | Input-pin levels |
| cnt_now | input | 16 | Live counter value |
| mode1_a | output | 8 | Channel A first mode byte |
| mode2_a | output | 8 | Channel A second mode byte |
| mode1_b | output | 8 | Channel B first mode byte |
| mode2_b | output | 8 | Channel B second mode byte |
| clk_sel_a | output | 8 | Channel A clock select |
| clk_sel_b | output | 8 | Channel B clock select |
| aux_ctl | output | 8 | Auxiliary control |
| irq_mask | output | 8 | Interrupt mask |
| irq_vec | output | 8 | Interrupt vector |
| pin_cfg | output | 8 | Output-pin configuration |
| pin_out | output | 8 | Output-pin levels |
| cnt_load | output | 16 | Counter preload |
| rx_pop | output | 2 | Receive pop strobes, bit 0 = A |
| tx_push | output | 2 | Transmit push strobes, bit 0 = A |
| cmd_stb | output | 2 | Command strobes, bit 0 = A |
| stb_data | output | 8 | Byte of the last write |
| cnt_start | output | 1 | Counter start strobe |
| cnt_stop | output | 1 | Counter stop strobe |

## Verification
The case hardest to reach from the ports is a mode pointer that is back on the first mode byte while the other channel's pointer stays on the second. The pointer is not visible on any port. Its position can only be inferred from which mode byte a read returns.

The stimulus first loads distinct values into both mode bytes of each channel. It then issues the pointer-reset command on one channel only and reads both channels' mode offsets. One of those reads is held for several cycles, to show that a long access moves the pointer once and pops nothing.

// File: rtl/dsh_pkg.sv
// Package: shared constants for the host register front end.
// Assumes a 4-bit offset space; per-channel offsets repeat every 8 locations.
package dsh_pkg;
    localparam int NCH = 2;
    // Channel-local offsets (low three address bits).
    localparam logic [2:0] LOC_MODE = 3'd0;
    localparam logic [2:0] LOC_SEL  = 3'd1;
    localparam logic [2:0] LOC_CMD  = 3'd2;
    localparam logic [2:0] LOC_HOLD = 3'd3;
    // Shared offsets.
    localparam logic [3:0] OFS_AUX  = 4'h4;
    localparam logic [3:0] OFS_MASK = 4'h5;
    localparam logic [3:0] OFS_CHI  = 4'h6;
    localparam logic [3:0] OFS_CLO  = 4'h7;
    localparam logic [3:0] OFS_VEC  = 4'hC;
    localparam logic [3:0] OFS_PCFG = 4'hD;
    localparam logic [3:0] OFS_SETP = 4'hE;
    localparam logic [3:0] OFS_CLRP = 4'hF;
    localparam logic [3:0] OFS_MSKR = 4'h2;
    // Command field code that sends a mode pointer back to the first byte.
    localparam logic [2:0] PTR_RST_CODE = 3'b001;
endpackage

// File: rtl/dsh_access.sv
// Module: dsh_access
// Turns a level-held bus access into single-cycle read/write go pulses.
// Assumes each access is separated by at least one idle cycle.
module dsh_access (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd_en,
    input  logic wr_en,
    output logic rd_go,
    output logic wr_go
);
    logic act, act_q;

    assign act = sel & (rd_en | wr_en);

    // Remember whether the previous cycle was already inside an access.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // First active cycle only; a read wins over a simultaneous write.
    always_comb begin
        rd_go = act & ~act_q & rd_en;
        wr_go = act & ~act_q & ~rd_en;
    end

    // R12
    go_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go || wr_go) |=> !(rd_go || wr_go));
endmodule

// File: rtl/dsh_chan.sv
// Module: dsh_chan
// Per-channel state: the mode byte pair with its pointer, clock select,
// and the channel strobes. Assumes at most one decoded access per cycle.
module dsh_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mr_rd,
    input  logic          mr_wr,
    input  logic          cs_wr,
    input  logic          cr_wr,
    input  logic          hr_rd,
    input  logic          hr_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode1,
    output logic [DW-1:0] mode2,
    output logic [DW-1:0] clk_sel,
    output logic          ptr,
    output logic          cmd_stb,
    output logic          tx_push,
    output logic          rx_pop
);
    import dsh_pkg::*;

    logic rst_cmd;
    assign rst_cmd = cr_wr && (wdata[6:4] == PTR_RST_CODE);

    // Mode pointer: advance on any mode access, return on reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr <= 1'b0;
        else if (rst_cmd)        ptr <= 1'b0;
        else if (mr_rd || mr_wr) ptr <= 1'b1;
    end

    // Mode byte pair and clock select storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode1   <= '0;
            mode2   <= '0;
            clk_sel <= '0;
        end else begin
            if (mr_wr && !ptr) mode1   <= wdata;
            if (mr_wr &&  ptr) mode2   <= wdata;
            if (cs_wr)         clk_sel <= wdata;
        end
    end

    // Single-cycle strobes towards the channel logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb <= 1'b0;
            tx_push <= 1'b0;
            rx_pop  <= 1'b0;
        end else begin
            cmd_stb <= cr_wr && !rst_cmd;
            tx_push <= hr_wr;
            rx_pop  <= hr_rd;
        end
    end

    // R6
    ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_rd || mr_wr) |=> ptr);
    // R6
    mr1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_wr && ptr) |=> $stable(mode1));
    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr && !cr_wr) |=> ptr);
    // R7
    ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && wdata[6:4] == 3'b001) |=> (!ptr && !cmd_stb));
endmodule

// File: rtl/dsh_oport.sv
// Module: dsh_oport
// Output-pin byte driven by set-bits and clear-bits commands.
// Assumes set and clear never arrive in the same cycle.
module dsh_oport #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_go,
    input  logic          clr_go,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] pin_out
);
    // Apply the set or clear mask to the pin byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      pin_out <= '0;
        else if (set_go) pin_out <= pin_out | wdata;
        else if (clr_go) pin_out <= pin_out & ~wdata;
    end

    // R11
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_go |=> ((pin_out & $past(wdata)) == $past(wdata)));
    // R11
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> ((pin_out & $past(wdata)) == '0));
    // R11
    pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_go && !clr_go) |=> $stable(pin_out));
endmodule

// File: rtl/dsh_host_regs.sv
// Module: dsh_host_regs
// Host register front end for a two-channel serial controller: address
// decode, shared configuration storage, registered read mux and strobes.
// Assumes a synchronous host bus with accesses separated by an idle cycle.
module dsh_host_regs #(
    parameter int DW = 8,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] stat_a,
    input  logic [DW-1:0] stat_b,
    input  logic [DW-1:0] rxd_a,
    input  logic [DW-1:0] rxd_b,
    input  logic [DW-1:0] irq_src,
    input  logic [DW-1:0] pin_chg,
    input  logic [DW-1:0] pin_lvl,
    input  logic [CW-1:0] cnt_now,
    output logic [DW-1:0] mode1_a,
    output logic [DW-1:0] mode2_a,
    output logic [DW-1:0] mode1_b,
    output logic [DW-1:0] mode2_b,
    output logic [DW-1:0] clk_sel_a,
    output logic [DW-1:0] clk_sel_b,
    output logic [DW-1:0] aux_ctl,
    output logic [DW-1:0] irq_mask,
    output logic [DW-1:0] irq_vec,
    output logic [DW-1:0] pin_cfg,
    output logic [DW-1:0] pin_out,
    output logic [CW-1:0] cnt_load,
    output logic [1:0]    rx_pop,
    output logic [1:0]    tx_push,
    output logic [1:0]    cmd_stb,
    output logic [DW-1:0] stb_data,
    output logic          cnt_start,
    output logic          cnt_stop
);
    import dsh_pkg::*;

    logic rd_go, wr_go;
    logic [NCH-1:0]         ch_ptr;
    logic [NCH-1:0][DW-1:0] ch_m1, ch_m2, ch_cs;
    logic [NCH-1:0][DW-1:0] ch_stat, ch_rxd;

    assign ch_stat = {stat_b, stat_a};
    assign ch_rxd  = {rxd_b, rxd_a};

    dsh_access u_acc (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .rd_go(rd_go), .wr_go(wr_go)
    );

    // One channel instance per half of the map; bit 3 picks the channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = (addr[3] == c[0]) && !addr[2];
        dsh_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .mr_rd(rd_go && hit && addr[2:0] == LOC_MODE),
            .mr_wr(wr_go && hit && addr[2:0] == LOC_MODE),
            .cs_wr(wr_go && hit && addr[2:0] == LOC_SEL),
            .cr_wr(wr_go && hit && addr[2:0] == LOC_CMD),
            .hr_rd(rd_go && hit && addr[2:0] == LOC_HOLD),
            .hr_wr(wr_go && hit && addr[2:0] == LOC_HOLD),
            .wdata(wdata),
            .mode1(ch_m1[c]), .mode2(ch_m2[c]), .clk_sel(ch_cs[c]),
            .ptr(ch_ptr[c]), .cmd_stb(cmd_stb[c]),
            .tx_push(tx_push[c]), .rx_pop(rx_pop[c])
        );
    end

    assign mode1_a   = ch_m1[0];
    assign mode2_a   = ch_m2[0];
    assign mode1_b   = ch_m1[1];
    assign mode2_b   = ch_m2[1];
    assign clk_sel_a = ch_cs[0];
    assign clk_sel_b = ch_cs[1];

    dsh_oport #(.DW(DW)) u_op (
        .clk(clk), .rst_n(rst_n),
        .set_go(wr_go && addr == OFS_SETP),
        .clr_go(wr_go && addr == OFS_CLRP),
        .wdata(wdata), .pin_out(pin_out)
    );

    // Shared configuration bytes written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_ctl  <= '0;
            irq_mask <= '0;
            irq_vec  <= '0;
            pin_cfg  <= '0;
            cnt_load <= '0;
        end else if (wr_go) begin
            case (addr)
                OFS_AUX:  aux_ctl  <= wdata;
                OFS_MASK: irq_mask <= wdata;
                OFS_VEC:  irq_vec  <= wdata;
                OFS_PCFG: pin_cfg  <= wdata;
                OFS_CHI:  cnt_load[CW-1:DW] <= wdata;
                OFS_CLO:  cnt_load[DW-1:0]  <= wdata;
                default: ;
            endcase
        end
    end

    // Byte presented with write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     stb_data <= '0;
        else if (wr_go) stb_data <= wdata;
    end

    // Counter start/stop triggered by reads of the top two offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_start <= 1'b0;
            cnt_stop  <= 1'b0;
        end else begin
            cnt_start <= rd_go && addr == OFS_SETP;
            cnt_stop  <= rd_go && addr == OFS_CLRP;
        end
    end

    // Registered read mux, captured on the first cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_go) begin
            case (addr)
                4'h0:     rdata <= ch_ptr[0] ? ch_m2[0] : ch_m1[0];
                4'h1:     rdata <= ch_stat[0];
                OFS_MSKR: rdata <= irq_src & irq_mask;
                4'h3:     rdata <= ch_rxd[0];
                4'h4:     rdata <= pin_chg;
                4'h5:     rdata <= irq_src;
                4'h6:     rdata <= cnt_now[CW-1:DW];
                4'h7:     rdata <= cnt_now[DW-1:0];
                4'h8:     rdata <= ch_ptr[1] ? ch_m2[1] : ch_m1[1];
                4'h9:     rdata <= ch_stat[1];
                4'hB:     rdata <= ch_rxd[1];
                OFS_VEC:  rdata <= irq_vec;
                OFS_PCFG: rdata <= pin_lvl;
                default:  rdata <= '0;
            endcase
        end
    end

    // R4
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && addr == 4'h2) |=> (rdata == ($past(irq_src) & irq_mask)));
    // R5
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && addr == 4'hA) |=> (rdata == '0 && rx_pop == '0 && tx_push == '0
                                     && cmd_stb == '0 && !cnt_start && !cnt_stop));
    // R10
    cnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_start, cnt_stop}));
    // R12
    pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop != '0) |=> (rx_pop == '0));
endmodule

// File: tb/sim_dsh_host_regs.sv
`timescale 1ns/1ps
module sim_dsh_host_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 0, rd_en = 0, wr_en = 0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] stat_a = 8'h11, stat_b = 8'h22, rxd_a = 8'h33, rxd_b = 8'h44;
    logic [7:0] irq_src = 8'hA5, pin_chg = 8'h66, pin_lvl = 8'h77;
    logic [15:0] cnt_now = 16'h8899;
    logic [7:0] mode1_a, mode2_a, mode1_b, mode2_b, clk_sel_a, clk_sel_b;
    logic [7:0] aux_ctl, irq_mask, irq_vec, pin_cfg, pin_out, stb_data;
    logic [15:0] cnt_load;
    logic [1:0] rx_pop, tx_push, cmd_stb;
    logic cnt_start, cnt_stop;

    int checks = 0, fails = 0;
    bit done = 0;
    int sc [8];

    always #4 clk = ~clk;

    dsh_host_regs u0 (.*);

    // {wr, addr, data, view, req, expected}
    localparam int NV = 32;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 4'h1, 8'h5A, 4'd1, 4'd2, 8'h5A},   // R2
        {1'b1, 4'h9, 8'hC3, 4'd2, 4'd2, 8'hC3},   // R2
        {1'b1, 4'h4, 8'h0F, 4'd3, 4'd2, 8'h0F},   // R2
        {1'b1, 4'h5, 8'h3C, 4'd4, 4'd2, 8'h3C},   // R2
        {1'b1, 4'h6, 8'h12, 4'd5, 4'd2, 8'h12},   // R2
        {1'b1, 4'h7, 8'h34, 4'd6, 4'd2, 8'h34},   // R2
        {1'b1, 4'hC, 8'h9E, 4'd7, 4'd2, 8'h9E},   // R2
        {1'b1, 4'hD, 8'hF0, 4'd8, 4'd2, 8'hF0},   // R2
        {1'b0, 4'h1, 8'h00, 4'd0, 4'd3, 8'h11},   // R3
        {1'b0, 4'h3, 8'h00, 4'd0, 4'd3, 8'h33},   // R3
        {1'b0, 4'h4, 8'h00, 4'd0, 4'd3, 8'h66},   // R3
        {1'b0, 4'h5, 8'h00, 4'd0, 4'd3, 8'hA5},   // R3
        {1'b0, 4'h6, 8'h00, 4'd0, 4'd3, 8'h88},   // R3
        {1'b0, 4'h7, 8'h00, 4'd0, 4'd3, 8'h99},   // R3
        {1'b0, 4'h9, 8'h00, 4'd0, 4'd3, 8'h22},   // R3
        {1'b0, 4'hB, 8'h00, 4'd0, 4'd3, 8'h44},   // R3
        {1'b0, 4'hC, 8'h00, 4'd0, 4'd3, 8'h9E},   // R3
        {1'b0, 4'hD, 8'h00, 4'd0, 4'd3, 8'h77},   // R3
        {1'b0, 4'h2, 8'h00, 4'd0, 4'd4, 8'h24},   // R4
        {1'b1, 4'hE, 8'h81, 4'd9, 4'd11, 8'h81},  // R11
        {1'b1, 4'hE, 8'h0C, 4'd9, 4'd11, 8'h8D},  // R11
        {1'b1, 4'hF, 8'h05, 4'd9, 4'd11, 8'h88},  // R11
        {1'b1, 4'h0, 8'hA1, 4'd10, 4'd6, 8'hA1},  // R6
        {1'b1, 4'h0, 8'hB2, 4'd11, 4'd6, 8'hB2},  // R6
        {1'b0, 4'h0, 8'h00, 4'd10, 4'd6, 8'hA1},  // R6 first byte kept
        {1'b0, 4'h8, 8'h00, 4'd0, 4'd6, 8'h00},   // R6 read reaches first byte
        {1'b1, 4'h8, 8'hE5, 4'd13, 4'd6, 8'hE5},  // R6
        {1'b0, 4'h8, 8'h00, 4'd0, 4'd6, 8'hE5},   // R6
        {1'b1, 4'h2, 8'h10, 4'd11, 4'd7, 8'hB2},  // R7 pointer reset A
        {1'b0, 4'h0, 8'h00, 4'd0, 4'd7, 8'hA1},   // R7
        {1'b0, 4'h0, 8'h00, 4'd0, 4'd7, 8'hB2},   // R7
        {1'b0, 4'hA, 8'h00, 4'd0, 4'd5, 8'h00}    // R5
    };

    function automatic logic [7:0] view(input logic [3:0] v);
        case (v)
            4'd0:  return rdata;
            4'd1:  return clk_sel_a;
            4'd2:  return clk_sel_b;
            4'd3:  return aux_ctl;
            4'd4:  return irq_mask;
            4'd5:  return cnt_load[15:8];
            4'd6:  return cnt_load[7:0];
            4'd7:  return irq_vec;
            4'd8:  return pin_cfg;
            4'd9:  return pin_out;
            4'd10: return mode1_a;
            4'd11: return mode2_a;
            4'd12: return mode1_b;
            4'd13: return mode2_b;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tally();
        sc[0] += int'(rx_pop[0]);  sc[1] += int'(rx_pop[1]);
        sc[2] += int'(tx_push[0]); sc[3] += int'(tx_push[1]);
        sc[4] += int'(cmd_stb[0]); sc[5] += int'(cmd_stb[1]);
        sc[6] += int'(cnt_start);  sc[7] += int'(cnt_stop);
    endtask

    // One bus access held for 'hold' cycles, strobes counted throughout.
    task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d, input int hold);
        for (int i = 0; i < 8; i++) sc[i] = 0;
        @(negedge clk);
        sel = 1; rd_en = !w; wr_en = w; addr = a; wdata = d;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            tally();
        end
        sel = 0; rd_en = 0; wr_en = 0;
        @(negedge clk);
        tally();
    endtask

    function automatic int total();
        int t = 0;
        for (int i = 0; i < 8; i++) t += sc[i];
        return t;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 config", {mode1_a, mode2_b}, 16'h0000);
        check("R1 shared", {aux_ctl | irq_mask | irq_vec | pin_cfg, pin_out}, 16'h0000);
        check("R1 strobes", {rx_pop, tx_push, cmd_stb, cnt_start, cnt_stop, rdata}, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            acc(VEC[k][28], VEC[k][27:24], VEC[k][23:16], 1);
            check($sformatf("R%0d vec%0d", VEC[k][11:8], k),
                  {8'h00, view(VEC[k][15:12])}, {8'h00, VEC[k][7:0]});
        end

        // R9 pop on receive read, push with data on transmit write
        acc(1'b0, 4'h3, 8'h00, 1);
        check("R9 pop A", 16'(sc[0] * 16 + total()), 16'h0011);
        acc(1'b1, 4'hB, 8'h6C, 1);
        check("R9 push B", 16'(sc[3] * 16 + total()), 16'h0011);
        check("R9 push data", {8'h00, stb_data}, 16'h006C);
        // R8 plain command strobe
        acc(1'b1, 4'h2, 8'h20, 1);
        check("R8 cmd A", 16'(sc[4] * 16 + total()), 16'h0011);
        check("R8 cmd data", {8'h00, stb_data}, 16'h0020);
        // R7 pointer reset on B: no strobe, A untouched
        acc(1'b1, 4'hA, 8'h10, 1);
        check("R7 no cmd strobe", 16'(total()), 16'h0000);
        // R12 long read: one pointer move, no strobe
        acc(1'b0, 4'h8, 8'h00, 5);
        check("R12 long mode read", {8'h00, rdata}, 16'h0000);
        check("R12 long read strobes", 16'(total()), 16'h0000);
        acc(1'b0, 4'h8, 8'h00, 1);
        check("R7 B back on second", {8'h00, rdata}, 16'h00E5);
        acc(1'b0, 4'h0, 8'h00, 1);
        check("R7 A independent", {8'h00, rdata}, 16'h00B2);
        // R12 long receive read pops once
        acc(1'b0, 4'hB, 8'h00, 6);
        check("R12 pop once", 16'(sc[1] * 16 + total()), 16'h0011);
        // R12 long set-bits write acts once; data only sets its bits
        acc(1'b1, 4'hE, 8'h40, 4);
        check("R12 long set", {8'h00, pin_out}, 16'h00C8);
        // R10 counter start/stop
        acc(1'b0, 4'hE, 8'h00, 1);
        check("R10 start", 16'(sc[6] * 16 + total()), 16'h0011);
        check("R10 start data", {8'h00, rdata}, 16'h0000);
        acc(1'b0, 4'hF, 8'h00, 1);
        check("R10 stop", 16'(sc[7] * 16 + total()), 16'h0011);
        // R5 reserved read leaves state
        acc(1'b0, 4'hA, 8'h00, 1);
        check("R5 no strobes", 16'(total()), 16'h0000);
        check("R5 state kept", {irq_vec, pin_out}, 16'h9EC8);
        // R11 zero data bits leave the pin byte
        acc(1'b1, 4'hF, 8'h00, 1);
        check("R11 zero clear", {8'h00, pin_out}, 16'h00C8);
        // R1 reset returns pointer and clears storage
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 after reset", {mode2_a, pin_out}, 16'h0000);
        acc(1'b1, 4'h0, 8'h05, 1);
        check("R1 pointer at first", {mode1_a, mode2_a}, 16'h0500);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule